// File: doc/BRIEF.md
# Flash Command Sequencer with Status Register

This block sits between a host bus and the write engine of a flash array. The host writes command bytes on a 16-bit data bus with an address, framed by active-low chip-enable and write-enable strobes. The sequencer decodes each write into an action. Some commands change the read mode. Some start a two-write program or erase sequence. Some clear error flags. Others pause or continue the operation in progress.

A small write engine models the time an operation takes. It holds the device busy for a fixed, parameterised number of clock cycles. A suspend freezes that count and a resume lets it continue from where it stopped. The block reports its state through an 8-bit status word. A separate output tells the read path whether reads should return status or array data. That read-mode choice holds until another command changes it.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `status` reads 8'h80 and `rd_status` is 0 (array mode). The status bit meanings are: bit 7 ready (1 = idle, 0 = busy), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 2 program suspended. Bits 3, 1 and 0 always read 0.
- R2: A bus write is the interval in which `bus_ce_n` and `bus_we_n` are both sampled low. It takes effect at the first clock edge where either strobe is sampled high, whichever strobe rises first. The address and data used are the values sampled in the last clock cycle of that interval.
- R3: In the idle state, byte 8'h20 followed by a write of 8'h D0 starts an erase. Status bit 7 is then 0 for exactly BUSY_CYCLES clock cycles, and `op_addr` holds the address of the confirm write.
- R4: In the idle state, byte 8'h40 followed by any write starts a program. That second write's data appears on `op_data` and its address on `op_addr`, and status bit 7 is 0 for exactly BUSY_CYCLES cycles.
- R5: After 8'h20, any second byte other than 8'hD0 aborts the sequence. It sets status bits 5 and 4, and status bit 7 stays 1.
- R6: Status bits 5 and 4 stay set through every command until byte 8'h50 is written in the idle state. That write clears both bits.
- R7: Byte 8'h70 sets `rd_status` to 1, and it stays 1 across later writes that do not change the mode. Byte 8'hFF sets it to 0. Byte 8'h20, 8'h40, or a resume also set it to 1.
- R8: Byte 8'hB0 written while busy suspends the operation. Status bit 7 goes to 1, and bit 6 is set for an erase or bit 2 for a program. The busy count stops while suspended.
- R9: Byte 8'hD0 written while suspended clears the suspend bit and resumes the operation. The remaining busy time is BUSY_CYCLES minus the cycles already spent busy.
- R10: While busy, every byte except 8'hB0 and 8'h70 is ignored. It changes neither `rd_status`, `op_addr` nor the busy duration.
- R11: While suspended, every byte except 8'hD0, 8'h70 and 8'hFF is ignored. A new 8'h40 leaves the operation suspended and does not start a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_ce_n | input | 1 | Active-low chip enable of the host write |
| bus_we_n | input | 1 | Active-low write enable of the host write |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | DATA_W | Write data; the command byte is bits 7:0 |
| rd_status | output | 1 | 1 selects status data for reads, 0 selects array data |
| status | output | 8 | Status word |
| op_addr | output | ADDR_W | Target address of the current or last operation |
| op_data | output | DATA_W | Data word of the current or last program |

## Verification
The bench builds the block with BUSY_CYCLES = 6 and the default 20-bit address and 16-bit data widths. With six busy cycles, a suspend or an ignored command can be written in the middle of an operation. Each bus write takes three clock edges, so exactly three busy cycles have passed when that write takes effect. The bench can then predict the remaining time of three cycles after a resume and check it to the cycle. The short count also keeps every erase and program scenario within a few dozen cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ERS_SETUP,
    SEQ_PGM_SETUP,
    SEQ_ERS_BUSY,
    SEQ_PGM_BUSY,
    SEQ_ERS_SUSP,
    SEQ_PGM_SUSP
  } seq_state_t;
endpackage

// File: rtl/fcc_bus_capture.sv
module fcc_bus_capture #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  logic wr_active;
  logic act_q;

  assign wr_active = ~ce_n & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      act_q <= wr_active;
      if (wr_active) begin
        cmd_addr <= addr;
        cmd_data <= data;
      end
    end
  end

  // first strobe to rise ends the write
  assign cmd_valid = act_q & ~wr_active;
endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pause,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          running;

  assign running = (cnt_q != '0) & ~pause;

  always_comb begin
    cnt_nxt = cnt_q;
    if (start)        cnt_nxt = LOAD;
    else if (running) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign done = running & (cnt_q == CW'(1));
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wsm_done,
  output logic              wsm_start,
  output logic              wsm_pause,
  output logic              rd_status,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  seq_state_t        st_q, st_nxt;
  logic              rd_q, rd_nxt;
  logic              eerr_q, eerr_nxt;
  logic              perr_q, perr_nxt;
  logic [ADDR_W-1:0] oa_q, oa_nxt;
  logic [DATA_W-1:0] od_q, od_nxt;
  logic [7:0]        cb;
  logic              is_busy;

  assign cb = cmd_data[7:0];

  always_comb begin
    st_nxt    = st_q;
    rd_nxt    = rd_q;
    eerr_nxt  = eerr_q;
    perr_nxt  = perr_q;
    oa_nxt    = oa_q;
    od_nxt    = od_q;
    wsm_start = 1'b0;
    case (st_q)
      SEQ_IDLE: if (cmd_valid) begin
        case (cb)
          CMD_ERASE:   begin st_nxt = SEQ_ERS_SETUP; rd_nxt = 1'b1; end
          CMD_PROGRAM: begin st_nxt = SEQ_PGM_SETUP; rd_nxt = 1'b1; end
          CMD_STATUS:  rd_nxt = 1'b1;
          CMD_ARRAY:   rd_nxt = 1'b0;
          CMD_CLEAR:   begin eerr_nxt = 1'b0; perr_nxt = 1'b0; end
          default: ;
        endcase
      end
      SEQ_ERS_SETUP: if (cmd_valid) begin
        rd_nxt = 1'b1;
        if (cb == CMD_CONFIRM) begin
          st_nxt    = SEQ_ERS_BUSY;
          wsm_start = 1'b1;
          oa_nxt    = cmd_addr;
        end else begin
          st_nxt   = SEQ_IDLE;
          eerr_nxt = 1'b1;
          perr_nxt = 1'b1;
        end
      end
      SEQ_PGM_SETUP: if (cmd_valid) begin
        rd_nxt    = 1'b1;
        st_nxt    = SEQ_PGM_BUSY;
        wsm_start = 1'b1;
        oa_nxt    = cmd_addr;
        od_nxt    = cmd_data;
      end
      SEQ_ERS_BUSY, SEQ_PGM_BUSY: begin
        if (cmd_valid && cb == CMD_STATUS) rd_nxt = 1'b1;
        if (wsm_done)
          st_nxt = SEQ_IDLE;
        else if (cmd_valid && cb == CMD_SUSPEND)
          st_nxt = (st_q == SEQ_ERS_BUSY) ? SEQ_ERS_SUSP : SEQ_PGM_SUSP;
      end
      SEQ_ERS_SUSP, SEQ_PGM_SUSP: if (cmd_valid) begin
        case (cb)
          CMD_CONFIRM: begin
            rd_nxt = 1'b1;
            st_nxt = (st_q == SEQ_ERS_SUSP) ? SEQ_ERS_BUSY : SEQ_PGM_BUSY;
          end
          CMD_STATUS: rd_nxt = 1'b1;
          CMD_ARRAY:  rd_nxt = 1'b0;
          default: ;
        endcase
      end
      default: st_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      rd_q   <= 1'b0;
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
      oa_q   <= '0;
      od_q   <= '0;
    end else begin
      st_q   <= st_nxt;
      rd_q   <= rd_nxt;
      eerr_q <= eerr_nxt;
      perr_q <= perr_nxt;
      oa_q   <= oa_nxt;
      od_q   <= od_nxt;
    end
  end

  assign is_busy   = (st_q == SEQ_ERS_BUSY) | (st_q == SEQ_PGM_BUSY);
  assign wsm_pause = (st_q == SEQ_ERS_SUSP) | (st_q == SEQ_PGM_SUSP);
  assign rd_status = rd_q;
  assign op_addr   = oa_q;
  assign op_data   = od_q;
  assign status    = {~is_busy, st_q == SEQ_ERS_SUSP, eerr_q, perr_q,
                      1'b0, st_q == SEQ_PGM_SUSP, 2'b00};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rd_status,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              wsm_start, wsm_pause, wsm_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fcc_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .ce_n(bus_ce_n), .we_n(bus_we_n),
    .addr(bus_addr), .data(bus_data),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fcc_wsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_wsm (
    .clk(clk), .rst_n(rst_int_n), .start(wsm_start), .pause(wsm_pause),
    .done(wsm_done)
  );

  fcc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wsm_done(wsm_done),
    .wsm_start(wsm_start), .wsm_pause(wsm_pause), .rd_status(rd_status),
    .status(status), .op_addr(op_addr), .op_data(op_data)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_byte,
  input logic              rd_status,
  input logic [7:0]        status,
  input logic [ADDR_W-1:0] op_addr
);
  // R8
  busy_not_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> (!status[6] && !status[2]));

  // R8
  one_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[6], status[2]}));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !(cmd_valid && cmd_byte == 8'h50)) |=> status[5]);

  // R7
  status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h70) |=> rd_status);

  // R3
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |=> $stable(op_addr));

  // R1
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] == 1'b0) && (status[1:0] == 2'b00));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_data[7:0]),
  .rd_status(rd_status), .status(status), .op_addr(op_addr)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BUSY = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          rd_status;
  logic [7:0]    status;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_data(data), .rd_status(rd_status),
    .status(status), .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // entered at a negedge; the write takes effect at the third edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_first);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    data = 16'hDEAD;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!status[7] && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset mode", rd_status, 0);
  endtask

  task automatic t_mode;
    wr(20'h0, 16'h0070, 0);
    chk("R7 status mode", rd_status, 1);
    wr(20'h0, 16'h0012, 0);
    chk("R7 mode sticky", rd_status, 1);
    wr(20'h0, 16'h00FF, 1);
    chk("R7 array mode", rd_status, 0);
  endtask

  task automatic t_erase;
    int n;
    wr(20'h0, 16'h0020, 0);
    chk("R7 erase setup mode", rd_status, 1);
    wr(20'h3_1000, 16'h00D0, 1);
    chk("R3 busy", status, 8'h00);
    chk("R3 op_addr", op_addr, 20'h3_1000);
    busy_len(n);
    chk("R3 busy cycles", n, BUSY);
    chk("R3 ready", status, 8'h80);
  endtask

  task automatic t_program;
    int n;
    wr(20'h0, 16'h0040, 0);
    wr(20'h0_0ABC, 16'h5A3C, 0);
    chk("R4 op_data", op_data, 16'h5A3C);
    chk("R4 op_addr", op_addr, 20'h0_0ABC);
    busy_len(n);
    chk("R4 busy cycles", n, BUSY);
  endtask

  task automatic t_capture;
    int n;
    wr(20'h0, 16'h0040, 1);
    addr = 20'h1_1111; data = 16'h1111; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = 20'h2_2222; data = 16'h2222;
    @(negedge clk);
    we_n = 1'b1; addr = 20'h3_3333; data = 16'h3333;
    @(negedge clk);
    ce_n = 1'b1;
    chk("R2 last data", op_data, 16'h2222);
    chk("R2 last addr", op_addr, 20'h2_2222);
    busy_len(n);
    chk("R2 busy from first rise", n, BUSY);
  endtask

  task automatic t_bad_confirm;
    wr(20'h0, 16'h0020, 0);
    wr(20'h0, 16'h0077, 0);
    chk("R5 error bits, no busy", status, 8'hB0);
    wr(20'h0, 16'h0070, 0);
    wr(20'h0, 16'h00FF, 0);
    chk("R6 errors sticky", status, 8'hB0);
    wr(20'h0, 16'h0050, 0);
    chk("R6 clear", status, 8'h80);
  endtask

  task automatic t_erase_suspend;
    int n;
    wr(20'h0, 16'h0020, 0);
    wr(20'h4_0000, 16'h00D0, 0);
    wr(20'h0, 16'h00B0, 0);
    chk("R8 erase suspended", status, 8'hC0);
    repeat (10) @(negedge clk);
    chk("R8 still suspended", status, 8'hC0);
    wr(20'h0, 16'h0040, 0);
    chk("R11 40h ignored", status, 8'hC0);
    wr(20'h0, 16'h00FF, 0);
    chk("R11 array mode in suspend", rd_status, 0);
    wr(20'h0, 16'h00D0, 0);
    chk("R9 resumed", status, 8'h00);
    chk("R9 resume mode", rd_status, 1);
    busy_len(n);
    chk("R9 remaining", n, BUSY - 3);
    chk("R11 no program started", status, 8'h80);
  endtask

  task automatic t_program_suspend;
    int n;
    wr(20'h0, 16'h0040, 0);
    wr(20'h0_0010, 16'hBEEF, 0);
    wr(20'h0, 16'h00B0, 1);
    chk("R8 program suspended", status, 8'h84);
    wr(20'h0, 16'h00D0, 0);
    busy_len(n);
    chk("R9 program remaining", n, BUSY - 3);
  endtask

  task automatic t_busy_ignore;
    int n;
    wr(20'h0, 16'h0020, 0);
    wr(20'h5_0000, 16'h00D0, 0);
    wr(20'h6_0000, 16'h00FF, 0);
    chk("R10 mode kept", rd_status, 1);
    chk("R10 op_addr kept", op_addr, 20'h5_0000);
    busy_len(n);
    chk("R10 duration kept", n, BUSY - 3);
    chk("R10 mode after", rd_status, 1);
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode();
    t_erase();
    t_program();
    t_capture();
    t_bad_confirm();
    t_erase_suspend();
    t_program_suspend();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule